// File: doc/BRIEF.md
# Cascaded Match and Full Flag Chain

This block is the per-device cascade logic placed beside a search array so that several devices wired in a vertical chain produce a single system match flag and a single system full flag, with no extra glue between them. Each device takes a match-in from the device above it and passes a match-out to the device below. The device above has higher priority. A full-in / full-out pair is chained the same way, so the last device reports that the whole system has no free entry.

All chain signals are active-low. The first device in a chain has its match-in tied high (no upstream match) and its full-in tied low (an empty upstream is treated as full). The chain is armed by a chain-enable input. That input is sampled when the bus enable strobe falls, and the new setting takes effect after the strobe rises. Two control bits enable the local contribution to match-out and to full-out. When a bit is off, that output is a pure pass-through of its upstream input. The local match and multiple-match pins report the device's own latest compare result without any chain qualification. A change of the active configuration set clears them and disarms the chain.

Top module: `cascade_flag_chain`

## Requirements
- R1: After reset, matchOutN, devMatchN and devMultiN are 1, ownsMatch is 0, and the chain is disarmed.
- R2: chainEnN is sampled only in the cycle where enStrobeN goes from 1 to 0 (seen at a clock edge). Its value at any other time has no effect on the arming that follows.
- R3: The sampled chain setting takes effect at the clock edge where enStrobeN is seen going from 0 to 1. While the chain is disarmed, matchOutN is 1.
- R4: When armed with matchFlagEn=1, matchOutN is 0 exactly when matchInN is 0 or the device's latest compare hit.
- R5: When armed with matchFlagEn=0, matchOutN equals matchInN.
- R6: With fullFlagEn=1, fullOutN is 0 only when fullInN is 0 and hasEmpty is 0. With fullFlagEn=0, fullOutN equals fullInN. The chain arming does not gate this output.
- R7: devMatchN is the inverse of cmpHit captured on the last clock edge with cmpValid=1, held until the next compare. It is independent of chainEnN and matchInN.
- R8: devMultiN is 0 only when the captured compare had both cmpHit=1 and cmpMulti=1.
- R9: cfgSwap=1 at a clock edge clears the stored compare result and disarms the chain. It wins over a compare loaded in the same edge, so afterwards devMatchN, devMultiN and matchOutN are 1.
- R10: ownsMatch is 1 when the chain is armed, matchFlagEn=1, matchInN=1 and the latest compare hit.
- R11: In a chain of devices, exactly the highest-priority device with a hit owns the result, and the last device's matchOutN is 0 whenever any armed device with the flag enabled hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enStrobeN | input | 1 | Bus cycle enable strobe, active low |
| chainEnN | input | 1 | Chain enable, active low, sampled when the strobe falls |
| cfgSwap | input | 1 | Pulse: active configuration set changed |
| cmpValid | input | 1 | A compare result is presented this cycle |
| cmpHit | input | 1 | Compare found at least one valid match |
| cmpMulti | input | 1 | Compare found more than one valid match |
| hasEmpty | input | 1 | Local array still has an empty entry |
| matchFlagEn | input | 1 | Enables the local contribution to match-out |
| fullFlagEn | input | 1 | Enables the local contribution to full-out |
| matchInN | input | 1 | Match-out of the higher-priority device, active low |
| fullInN | input | 1 | Full-out of the upstream device, active low |
| matchOutN | output | 1 | Chained match flag, active low |
| fullOutN | output | 1 | Chained full flag, active low |
| devMatchN | output | 1 | Unqualified local match, active low |
| devMultiN | output | 1 | Unqualified local multiple match, active low |
| ownsMatch | output | 1 | This device holds the system match result |

## Verification
The stored state (strobe history, sampled chain setting, armed flag and compare result) updates on the clock edge where its stimulus is present. Any output that depends on it is therefore due just after that edge. The chain outputs matchOutN, fullOutN and ownsMatch are combinational from that state and from the upstream inputs, so they ripple through all three devices within the same cycle. The bench drives inputs at the falling clock edge, advances its own model at the rising edge, and compares every output of every device one nanosecond after the rising edge, well before the inputs next change.

// File: rtl/cascade_chain_pkg.sv
package cascade_chain_pkg;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic latchChain;  // capture chain enable (strobe fall)
    logic armChain;    // apply captured chain setting (strobe rise)
    logic loadStatus;  // capture a compare result
    logic clearAll;    // configuration set change
  } chainStrobes_t;

endpackage

// File: rtl/cascade_chain_ctrl.sv
module cascade_chain_ctrl
  import cascade_chain_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          enStrobeN,
  input  logic          chainEnN,
  input  logic          cmpValid,
  input  logic          cfgSwap,
  output chainStrobes_t strobes,
  output logic          chainReq
);

  logic strobePrev;
  logic fallEdge;
  logic riseEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b1;
    else       strobePrev <= enStrobeN;
  end

  assign fallEdge = strobePrev & ~enStrobeN;
  assign riseEdge = ~strobePrev & enStrobeN;

  always_comb begin
    strobes.latchChain = fallEdge;
    strobes.armChain   = riseEdge & ~cfgSwap;
    strobes.loadStatus = cmpValid & ~cfgSwap;
    strobes.clearAll   = cfgSwap;
  end

  // chain request captured at the strobe fall, held until the next fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   chainReq <= 1'b0;
    else if (strobes.latchChain) chainReq <= ~chainEnN;
  end

endmodule

// File: rtl/cascade_chain_dp.sv
module cascade_chain_dp
  import cascade_chain_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  chainStrobes_t strobes,
  input  logic          chainReq,
  input  logic          cmpHit,
  input  logic          cmpMulti,
  input  logic          hasEmpty,
  input  logic          matchFlagEn,
  input  logic          fullFlagEn,
  input  logic          matchInN,
  input  logic          fullInN,
  output logic          matchOutN,
  output logic          fullOutN,
  output logic          devMatchN,
  output logic          devMultiN,
  output logic          ownsMatch
);

  logic chainActive;
  logic statusHit;
  logic statusMulti;
  logic localDrive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 chainActive <= 1'b0;
    else if (strobes.clearAll) chainActive <= 1'b0;
    else if (strobes.armChain) chainActive <= chainReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusHit   <= 1'b0;
      statusMulti <= 1'b0;
    end else if (strobes.clearAll) begin
      statusHit   <= 1'b0;
      statusMulti <= 1'b0;
    end else if (strobes.loadStatus) begin
      statusHit   <= cmpHit;
      statusMulti <= cmpHit & cmpMulti;
    end
  end

  assign localDrive = matchFlagEn & statusHit;

  // match chain: disarmed -> held inactive; else upstream OR local
  assign matchOutN = chainActive ? (matchInN & ~localDrive) : 1'b1;
  assign ownsMatch = chainActive & matchInN & localDrive;

  // full chain: full only if upstream full and no local empty entry
  assign fullOutN  = fullFlagEn ? (fullInN | hasEmpty) : fullInN;

  assign devMatchN = ~statusHit;
  assign devMultiN = ~statusMulti;

endmodule

// File: rtl/cascade_flag_chain.sv
module cascade_flag_chain
  import cascade_chain_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic enStrobeN,
  input  logic chainEnN,
  input  logic cfgSwap,
  input  logic cmpValid,
  input  logic cmpHit,
  input  logic cmpMulti,
  input  logic hasEmpty,
  input  logic matchFlagEn,
  input  logic fullFlagEn,
  input  logic matchInN,
  input  logic fullInN,
  output logic matchOutN,
  output logic fullOutN,
  output logic devMatchN,
  output logic devMultiN,
  output logic ownsMatch
);

  chainStrobes_t strobes;
  logic          chainReq;

  cascade_chain_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enStrobeN (enStrobeN),
    .chainEnN  (chainEnN),
    .cmpValid  (cmpValid),
    .cfgSwap   (cfgSwap),
    .strobes   (strobes),
    .chainReq  (chainReq)
  );

  cascade_chain_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .chainReq    (chainReq),
    .cmpHit      (cmpHit),
    .cmpMulti    (cmpMulti),
    .hasEmpty    (hasEmpty),
    .matchFlagEn (matchFlagEn),
    .fullFlagEn  (fullFlagEn),
    .matchInN    (matchInN),
    .fullInN     (fullInN),
    .matchOutN   (matchOutN),
    .fullOutN    (fullOutN),
    .devMatchN   (devMatchN),
    .devMultiN   (devMultiN),
    .ownsMatch   (ownsMatch)
  );

endmodule

// File: rtl/cascade_chain_chk.sv
module cascade_chain_chk (
  input logic clk,
  input logic rstN,
  input logic cmpValid,
  input logic cfgSwap,
  input logic hasEmpty,
  input logic matchFlagEn,
  input logic fullFlagEn,
  input logic matchInN,
  input logic fullInN,
  input logic matchOutN,
  input logic fullOutN,
  input logic devMatchN,
  input logic devMultiN,
  input logic ownsMatch
);

  // R4
  match_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !matchOutN |-> (!matchInN || (!devMatchN && matchFlagEn)));

  // R5
  flag_off_no_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    !matchFlagEn |-> !ownsMatch);

  // R6
  full_needs_upstream_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fullOutN |-> !fullInN);

  // R6
  full_empty_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlagEn && hasEmpty) |-> fullOutN);

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpValid && !cfgSwap) |=> $stable(devMatchN) && $stable(devMultiN));

  // R8
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devMultiN |-> !devMatchN);

  // R9
  swap_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgSwap |=> (devMatchN && devMultiN && matchOutN && !ownsMatch));

  // R10
  owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    ownsMatch |-> (matchInN && !matchOutN && !devMatchN));

endmodule

bind cascade_flag_chain cascade_chain_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmpValid    (cmpValid),
  .cfgSwap     (cfgSwap),
  .hasEmpty    (hasEmpty),
  .matchFlagEn (matchFlagEn),
  .fullFlagEn  (fullFlagEn),
  .matchInN    (matchInN),
  .fullInN     (fullInN),
  .matchOutN   (matchOutN),
  .fullOutN    (fullOutN),
  .devMatchN   (devMatchN),
  .devMultiN   (devMultiN),
  .ownsMatch   (ownsMatch)
);

// File: tb/cascade_flag_chain_tb.sv
module cascade_flag_chain_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic       rstN, enStrobeN, chainEnN, cfgSwap, matchFlagEn, fullFlagEn;
  logic [2:0] cmpValid, cmpHit, cmpMulti, hasEmpty;
  logic [2:0] matchOutN, fullOutN, devMatchN, devMultiN, ownsMatch;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // bench model state
  logic       mPrev, mSampled, mArmed;
  logic [2:0] mHit, mMulti;

  cascade_flag_chain u_dut (
    .clk(clk), .rstN(rstN), .enStrobeN(enStrobeN), .chainEnN(chainEnN),
    .cfgSwap(cfgSwap), .cmpValid(cmpValid[0]), .cmpHit(cmpHit[0]),
    .cmpMulti(cmpMulti[0]), .hasEmpty(hasEmpty[0]),
    .matchFlagEn(matchFlagEn), .fullFlagEn(fullFlagEn),
    .matchInN(1'b1), .fullInN(1'b0),
    .matchOutN(matchOutN[0]), .fullOutN(fullOutN[0]),
    .devMatchN(devMatchN[0]), .devMultiN(devMultiN[0]), .ownsMatch(ownsMatch[0]));

  cascade_flag_chain u_dev1 (
    .clk(clk), .rstN(rstN), .enStrobeN(enStrobeN), .chainEnN(chainEnN),
    .cfgSwap(cfgSwap), .cmpValid(cmpValid[1]), .cmpHit(cmpHit[1]),
    .cmpMulti(cmpMulti[1]), .hasEmpty(hasEmpty[1]),
    .matchFlagEn(matchFlagEn), .fullFlagEn(fullFlagEn),
    .matchInN(matchOutN[0]), .fullInN(fullOutN[0]),
    .matchOutN(matchOutN[1]), .fullOutN(fullOutN[1]),
    .devMatchN(devMatchN[1]), .devMultiN(devMultiN[1]), .ownsMatch(ownsMatch[1]));

  cascade_flag_chain u_dev2 (
    .clk(clk), .rstN(rstN), .enStrobeN(enStrobeN), .chainEnN(chainEnN),
    .cfgSwap(cfgSwap), .cmpValid(cmpValid[2]), .cmpHit(cmpHit[2]),
    .cmpMulti(cmpMulti[2]), .hasEmpty(hasEmpty[2]),
    .matchFlagEn(matchFlagEn), .fullFlagEn(fullFlagEn),
    .matchInN(matchOutN[1]), .fullInN(fullOutN[1]),
    .matchOutN(matchOutN[2]), .fullOutN(fullOutN[2]),
    .devMatchN(devMatchN[2]), .devMultiN(devMultiN[2]), .ownsMatch(ownsMatch[2]));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mPrev = 1'b1; mSampled = 1'b0; mArmed = 1'b0; mHit = '0; mMulti = '0;
  endtask

  // model update from the requirements, applied at a rising clock edge
  task automatic modelEdge(input logic swp);
    logic fall, rise;
    fall = mPrev & ~enStrobeN;
    rise = ~mPrev & enStrobeN;
    if (swp)       mArmed = 1'b0;          // R9
    else if (rise) mArmed = mSampled;      // R3
    if (fall) mSampled = ~chainEnN;        // R2
    for (int d = 0; d < 3; d++) begin
      if (swp) begin
        mHit[d] = 1'b0; mMulti[d] = 1'b0;
      end else if (cmpValid[d]) begin
        mHit[d] = cmpHit[d]; mMulti[d] = cmpHit[d] & cmpMulti[d];
      end
    end
    mPrev = enStrobeN;
  endtask

  task automatic verifyAll();
    logic mi, fi, eMo, eFo, eOwn, anyHit;
    int   firstHit;
    mi = 1'b1; fi = 1'b0; firstHit = -1; anyHit = 1'b0;
    for (int d = 0; d < 3; d++) begin
      if (!mArmed)          eMo = 1'b1;
      else if (matchFlagEn) eMo = mi & ~mHit[d];
      else                  eMo = mi;
      eOwn = mArmed & matchFlagEn & mi & mHit[d];
      eFo  = fullFlagEn ? (fi | hasEmpty[d]) : fi;
      if (!mArmed)          chk("R3 matchOutN disarmed", matchOutN[d], eMo);
      else if (matchFlagEn) chk("R4 matchOutN", matchOutN[d], eMo);
      else                  chk("R5 matchOutN passthrough", matchOutN[d], eMo);
      chk("R6 fullOutN", fullOutN[d], eFo);
      chk("R7 devMatchN", devMatchN[d], ~mHit[d]);
      chk("R8 devMultiN", devMultiN[d], ~mMulti[d]);
      chk("R10 ownsMatch", ownsMatch[d], eOwn);
      if (mHit[d] && firstHit < 0) firstHit = d;
      anyHit = anyHit | mHit[d];
      mi = eMo; fi = eFo;
    end
    // R11: system flag and unique owner across the chain
    chk("R11 system match", matchOutN[2], ~(mArmed & matchFlagEn & anyHit));
    for (int d = 0; d < 3; d++)
      chk("R11 owner priority", ownsMatch[d],
          mArmed & matchFlagEn & (firstHit == d));
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge(cfgSwap);
    #1;
    verifyAll();
    @(negedge clk);
  endtask

  task automatic setCmp(input logic [2:0] v, input logic [2:0] h, input logic [2:0] m);
    cmpValid = v; cmpHit = h; cmpMulti = m;
  endtask

  initial begin
    rstN = 1'b0; enStrobeN = 1'b1; chainEnN = 1'b1; cfgSwap = 1'b0;
    matchFlagEn = 1'b1; fullFlagEn = 1'b1;
    cmpValid = '0; cmpHit = '0; cmpMulti = '0; hasEmpty = 3'b111;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int d = 0; d < 3; d++) begin
      chk("R1 matchOutN", matchOutN[d], 1'b1);
      chk("R1 devMatchN", devMatchN[d], 1'b1);
      chk("R1 devMultiN", devMultiN[d], 1'b1);
      chk("R1 ownsMatch", ownsMatch[d], 1'b0);
    end
    @(negedge clk);
    rstN = 1'b1;
    step();

    // load a hit in device 1 only
    setCmp(3'b111, 3'b010, 3'b000); step();
    setCmp(3'b000, 3'b000, 3'b000);

    // R2: strobe falls with chainEnN=1, then chainEnN drops mid-cycle
    chainEnN = 1'b1; enStrobeN = 1'b0; step();
    chainEnN = 1'b0; step(); step();
    enStrobeN = 1'b1; step();
    chk("R2 late chainEnN ignored", matchOutN[2], 1'b1);

    // R3: armed only after the rise
    chainEnN = 1'b0; enStrobeN = 1'b0; step();
    chainEnN = 1'b1; step();
    chk("R3 not armed before rise", matchOutN[1], 1'b1);
    enStrobeN = 1'b1; step();
    chk("R3 armed after rise", matchOutN[1], 1'b0);
    chk("R11 owner dev1", ownsMatch[1], 1'b1);

    // R8: multi needs hit
    setCmp(3'b001, 3'b001, 3'b001); step();
    chk("R8 multi with hit", devMultiN[0], 1'b0);
    setCmp(3'b001, 3'b000, 3'b001); step();
    chk("R8 multi without hit", devMultiN[0], 1'b1);

    // R9: swap wins over a same-edge compare
    setCmp(3'b111, 3'b111, 3'b111); cfgSwap = 1'b1; step();
    cfgSwap = 1'b0; setCmp(3'b000, 3'b000, 3'b000);
    chk("R9 swap clears local", devMatchN[2], 1'b1);
    chk("R9 swap disarms", matchOutN[2], 1'b1);

    // R6: all full with flags on
    hasEmpty = 3'b000; step();
    chk("R6 system full", fullOutN[2], 1'b0);
    hasEmpty = 3'b100; step();

    // constrained random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 3) == 0) enStrobeN = ~enStrobeN;
      chainEnN    = (($urandom % 4) == 0);
      cfgSwap     = (($urandom % 40) == 0);
      if (($urandom % 16) == 0) matchFlagEn = $urandom;
      if (($urandom % 16) == 0) fullFlagEn  = $urandom;
      cmpValid = $urandom; cmpHit = $urandom; cmpMulti = $urandom;
      hasEmpty = (($urandom % 2) == 0) ? 3'b000 : 3'($urandom);
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule